// File: doc/BRIEF.md
# Raster Timing Generator with Sync Control

This block produces the scan timing for a progressive (non-interlaced) raster display. Two counters step through the pixels of a line and the lines of a frame. Their values are decoded into an active-picture flag, horizontal and vertical sync pulses, a combined sync intended for embedding on the colour signal, and a one-cycle prefetch strobe that fires at a programmable point in every line. The pixel fetch path and the colour pipeline sit downstream and are not part of this block.

Software programs every timing value through a small write-only register bus as a position minus one. Each window runs from `position - 1` to `position - 1`, and both bounds are inclusive. A typical setup clears the run and refresh bits, loads the extents, sync windows and prefetch point, and then sets both bits again. A sync-control register selects the polarity of each sync. It can also silence the horizontal sync, the vertical sync or all sync, which gives the power-saving blanking states. A display-control bit forces the picture dark while the sync keeps running.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is applied and after it is released, every register reads as zero. The counters are 0, and `hsync`, `vsync`, `rgb_sync`, `display_active` and `prefetch` are all 0.
- R2: While the run bit (control register at address 0, bit 0) is set, `pixel_x` advances by one each clock. After the clock in which it is at or above the horizontal total (address 1), it returns to 0.
- R3: `pixel_y` changes only in the clock where `pixel_x` wraps. It then advances by one, and it returns to 0 after it has reached the vertical total (address 5).
- R4: While the run bit is clear, both counters are held at 0 and `prefetch`, `display_active` and `rgb_sync` are 0. `hsync` equals the horizontal invert bit and `vsync` equals the vertical invert bit.
- R5: The raw horizontal sync is true when `hs_start <= pixel_x <= hs_end` (addresses 3 and 4). The raw vertical sync is true when `vs_start <= pixel_y <= vs_end` (addresses 7 and 8). Both bounds are inclusive.
- R6: `display_active` is 1 exactly when the run bit and the refresh bit (address 0, bit 1) are set, the display-off bit is clear, `pixel_x <= h_active` (address 2) and `pixel_y <= v_active` (address 6).
- R7: `prefetch` is 1 for the single clock in which the run bit is set and `pixel_x` equals the prefetch point (address 9).
- R8: In the sync-control register (address 10), bit 3 inverts `hsync` and bit 4 inverts `vsync`. A set bit makes the sync active low.
- R9: Sync-control bit 5 holds `hsync` at its inactive level and bit 6 holds `vsync` at its inactive level. Bit 1 holds both syncs at their inactive levels and forces `rgb_sync` to 0.
- R10: With sync-control bit 0 set, `rgb_sync` is the OR of the raw horizontal and raw vertical sync, taken before inversion and unaffected by bits 5 and 6. With bit 0 clear, `rgb_sync` is 0.
- R11: Bit 1 of the display-control register (address 11) forces `display_active` to 0. The counters and the syncs are not affected.
- R12: Writes to addresses 12 to 15 change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | CW | Register write data |
| pixel_x | output | CW | Horizontal position within the line |
| pixel_y | output | CW | Line number within the frame |
| display_active | output | 1 | Inside the visible picture and not blanked |
| hsync | output | 1 | Horizontal sync at the programmed polarity |
| vsync | output | 1 | Vertical sync at the programmed polarity |
| prefetch | output | 1 | One-cycle strobe at the prefetch point of each line |
| rgb_sync | output | 1 | Combined active-high sync for embedding on colour |

## Verification
The hardest condition to reach is the boundary between adjacent lines. There the prefetch point can sit on pixel 0 or on the very last pixel of a line. A sync window can also end exactly on the line or frame total, so that the horizontal and vertical wrap happen in the same clock as a window edge. The stimulus table therefore includes configurations with the prefetch point at 0 and at the horizontal total, and windows that touch the totals. Each configuration runs for two whole frames and is compared in every clock against a model kept in the bench. The run bit is also cleared while the counters are in motion, so that the hold-at-zero state and the idle sync polarity are reached from a live scan rather than from reset.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int AW = 4;

  typedef enum logic [AW-1:0] {
    A_CTRL = 4'd0,
    A_HTOT = 4'd1,
    A_HACT = 4'd2,
    A_HSS  = 4'd3,
    A_HSE  = 4'd4,
    A_VTOT = 4'd5,
    A_VACT = 4'd6,
    A_VSS  = 4'd7,
    A_VSE  = 4'd8,
    A_PREF = 4'd9,
    A_SYNC = 4'd10,
    A_DISP = 4'd11
  } reg_addr_e;

  localparam int NUM_TIM = 9;   // timing registers at addresses 1..9

  // control register bits
  localparam int CB_RUN     = 0;
  localparam int CB_REFRESH = 1;
  // sync control bits
  localparam int SB_RGB     = 0;
  localparam int SB_ALL_OFF = 1;
  localparam int SB_H_INV   = 3;
  localparam int SB_V_INV   = 4;
  localparam int SB_H_OFF   = 5;
  localparam int SB_V_OFF   = 6;
  // display control bit
  localparam int DB_BLANK   = 1;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          run_en,
  output logic          refresh_en,
  output logic          rgb_sync_en,
  output logic          sync_all_off,
  output logic          h_inv,
  output logic          v_inv,
  output logic          h_off,
  output logic          v_off,
  output logic          blank,
  output logic [CW-1:0] ax_total   [2],
  output logic [CW-1:0] ax_act     [2],
  output logic [CW-1:0] ax_sync_lo [2],
  output logic [CW-1:0] ax_sync_hi [2],
  output logic [CW-1:0] pref_pt
);
  localparam int NF = 9;
  // flag layout: 0 run, 1 refresh, 2 rgb, 3 all-off, 4 h-inv, 5 v-inv,
  // 6 h-off, 7 v-off, 8 blank
  logic [NF-1:0] flag_q, flag_d;
  logic [CW-1:0] tim_q [NUM_TIM];
  logic [CW-1:0] tim_d [NUM_TIM];

  always_comb begin
    flag_d = flag_q;
    tim_d  = tim_q;
    if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          flag_d[0] = wr_data[CB_RUN];
          flag_d[1] = wr_data[CB_REFRESH];
        end
        A_SYNC: begin
          flag_d[2] = wr_data[SB_RGB];
          flag_d[3] = wr_data[SB_ALL_OFF];
          flag_d[4] = wr_data[SB_H_INV];
          flag_d[5] = wr_data[SB_V_INV];
          flag_d[6] = wr_data[SB_H_OFF];
          flag_d[7] = wr_data[SB_V_OFF];
        end
        A_DISP: flag_d[8] = wr_data[DB_BLANK];
        default: begin
          if (wr_addr >= A_HTOT && wr_addr <= A_PREF)
            tim_d[wr_addr - 4'd1] = wr_data;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      for (int i = 0; i < NUM_TIM; i++) tim_q[i] <= '0;
    end else if (wr_en) begin
      flag_q <= flag_d;
      tim_q  <= tim_d;
    end
  end

  assign run_en       = flag_q[0];
  assign refresh_en   = flag_q[1];
  assign rgb_sync_en  = flag_q[2];
  assign sync_all_off = flag_q[3];
  assign h_inv        = flag_q[4];
  assign v_inv        = flag_q[5];
  assign h_off        = flag_q[6];
  assign v_off        = flag_q[7];
  assign blank        = flag_q[8];

  assign ax_total[0]   = tim_q[0];
  assign ax_act[0]     = tim_q[1];
  assign ax_sync_lo[0] = tim_q[2];
  assign ax_sync_hi[0] = tim_q[3];
  assign ax_total[1]   = tim_q[4];
  assign ax_act[1]     = tim_q[5];
  assign ax_sync_lo[1] = tim_q[6];
  assign ax_sync_hi[1] = tim_q[7];
  assign pref_pt       = tim_q[8];
endmodule

// File: rtl/rtg_axis_counter.sv
module rtg_axis_counter #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [CW-1:0] last,
  output logic [CW-1:0] count,
  output logic          wrap
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wrap  = step && (cnt_q >= last);
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clr || step)  cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/rtg_window.sv
module rtg_window #(
  parameter int CW = 12
) (
  input  logic [CW-1:0] pos,
  input  logic [CW-1:0] lo,
  input  logic [CW-1:0] hi,
  output logic          hit
);
  assign hit = (pos >= lo) && (pos <= hi);
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] pixel_x,
  output logic [CW-1:0] pixel_y,
  output logic          display_active,
  output logic          hsync,
  output logic          vsync,
  output logic          prefetch,
  output logic          rgb_sync
);
  localparam int NAX = 2;

  // asynchronous assertion, synchronous release
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic run_en, refresh_en, rgb_sync_en, sync_all_off;
  logic h_inv, v_inv, h_off, v_off, blank;
  logic [CW-1:0] ax_total   [NAX];
  logic [CW-1:0] ax_act     [NAX];
  logic [CW-1:0] ax_sync_lo [NAX];
  logic [CW-1:0] ax_sync_hi [NAX];
  logic [CW-1:0] pref_pt;

  rtg_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(reg_we), .wr_addr(reg_addr), .wr_data(reg_wdata),
    .run_en(run_en), .refresh_en(refresh_en), .rgb_sync_en(rgb_sync_en),
    .sync_all_off(sync_all_off), .h_inv(h_inv), .v_inv(v_inv),
    .h_off(h_off), .v_off(v_off), .blank(blank),
    .ax_total(ax_total), .ax_act(ax_act),
    .ax_sync_lo(ax_sync_lo), .ax_sync_hi(ax_sync_hi), .pref_pt(pref_pt)
  );

  logic [CW-1:0] cnt      [NAX];
  logic          step     [NAX];
  logic          wrap     [NAX];
  logic          sync_hit [NAX];
  logic          act_hit  [NAX];

  assign step[0] = run_en;
  assign step[1] = wrap[0];

  for (genvar ax = 0; ax < NAX; ax++) begin : g_axis
    rtg_axis_counter #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_sync_n), .clr(!run_en), .step(step[ax]),
      .last(ax_total[ax]), .count(cnt[ax]), .wrap(wrap[ax])
    );
    rtg_window #(.CW(CW)) u_sync_win (
      .pos(cnt[ax]), .lo(ax_sync_lo[ax]), .hi(ax_sync_hi[ax]), .hit(sync_hit[ax])
    );
    assign act_hit[ax] = (cnt[ax] <= ax_act[ax]);
  end

  logic h_raw, v_raw;
  assign h_raw = run_en & sync_hit[0];
  assign v_raw = run_en & sync_hit[1];

  assign pixel_x        = cnt[0];
  assign pixel_y        = cnt[1];
  assign hsync          = (h_raw & ~h_off & ~sync_all_off) ^ h_inv;
  assign vsync          = (v_raw & ~v_off & ~sync_all_off) ^ v_inv;
  assign rgb_sync       = rgb_sync_en & ~sync_all_off & (h_raw | v_raw);
  assign display_active = run_en & refresh_en & ~blank & act_hit[0] & act_hit[1];
  assign prefetch       = run_en & (cnt[0] == pref_pt);
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          reg_we,
  input logic [CW-1:0] htot,
  input logic          all_off,
  input logic          h_inv,
  input logic          v_inv,
  input logic          blank,
  input logic [CW-1:0] pixel_x,
  input logic [CW-1:0] pixel_y,
  input logic          hsync,
  input logic          vsync,
  input logic          rgb_sync,
  input logic          display_active,
  input logic          prefetch
);
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pixel_x < htot) |=> pixel_x == CW'($past(pixel_x) + 1'b1));

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pixel_x >= htot) |=> pixel_x == '0);

  assert_vhold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pixel_x < htot) |=> $stable(pixel_y));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pixel_x == '0 && pixel_y == '0));

  assert_idle_pol_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (hsync == h_inv && vsync == v_inv && !prefetch && !display_active));

  assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (prefetch && htot != '0 && !reg_we) |=> !prefetch);

  assert_all_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    all_off |-> (hsync == h_inv && vsync == v_inv && !rgb_sync));

  assert_blank_R11: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> !display_active);
endmodule

bind raster_timing_gen rtg_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .en(run_en), .reg_we(reg_we),
  .htot(ax_total[0]), .all_off(sync_all_off), .h_inv(h_inv), .v_inv(v_inv),
  .blank(blank), .pixel_x(pixel_x), .pixel_y(pixel_y), .hsync(hsync),
  .vsync(vsync), .rgb_sync(rgb_sync), .display_active(display_active),
  .prefetch(prefetch)
);

// File: tb/sim_raster_timing_gen.sv
module sim_raster_timing_gen;
  localparam int CW = 12;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_we;
  logic [3:0]    reg_addr;
  logic [CW-1:0] reg_wdata;
  logic [CW-1:0] pixel_x, pixel_y;
  logic          display_active, hsync, vsync, prefetch, rgb_sync;

  always #(CLK_PERIOD / 2) clk = ~clk;

  raster_timing_gen #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .pixel_x(pixel_x), .pixel_y(pixel_y),
    .display_active(display_active), .hsync(hsync), .vsync(vsync),
    .prefetch(prefetch), .rgb_sync(rgb_sync)
  );

  typedef struct packed {
    logic [11:0] ht, ha, hs, he, vt, va, vs, ve, pf, sc, dc, cr;
  } cfg_t;

  localparam int NCFG = 5;
  localparam cfg_t TABLE [NCFG] = '{
    '{12'd9,  12'd5, 12'd7, 12'd8, 12'd5, 12'd3, 12'd4, 12'd4, 12'd6,  12'h00, 12'h0, 12'h3},
    '{12'd9,  12'd5, 12'd7, 12'd9, 12'd5, 12'd3, 12'd4, 12'd5, 12'd9,  12'h18, 12'h0, 12'h3},
    '{12'd7,  12'd3, 12'd4, 12'd6, 12'd3, 12'd1, 12'd2, 12'd3, 12'd0,  12'h21, 12'h2, 12'h3},
    '{12'd11, 12'd7, 12'd8, 12'd9, 12'd4, 12'd2, 12'd3, 12'd3, 12'd11, 12'h52, 12'h0, 12'h1},
    '{12'd9,  12'd4, 12'd0, 12'd2, 12'd5, 12'd2, 12'd0, 12'd1, 12'd3,  12'h49, 12'h0, 12'h3}
  };

  int   n_checks = 0;
  int   n_errors = 0;
  bit   finished = 1'b0;
  cfg_t cur;
  int   ex, ey;

  task automatic chk(input int act, input int exp, input string tag);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual %0d expected %0d (x=%0d y=%0d)", tag, act, exp, ex, ey);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    reg_we    = 1'b1;
    reg_addr  = 4'(addr);
    reg_wdata = CW'(data);
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic program_cfg(input cfg_t c);
    wr(0, 0);
    wr(1, int'(c.ht)); wr(2, int'(c.ha)); wr(3, int'(c.hs)); wr(4, int'(c.he));
    wr(5, int'(c.vt)); wr(6, int'(c.va)); wr(7, int'(c.vs)); wr(8, int'(c.ve));
    wr(9, int'(c.pf)); wr(10, int'(c.sc)); wr(11, int'(c.dc));
    wr(0, int'(c.cr));
  endtask

  // compare all outputs against the bench model for a number of frames
  task automatic run_frames(input int frames);
    bit hr, vr;
    ex = 0;
    ey = 0;
    repeat (frames * (int'(cur.ht) + 1) * (int'(cur.vt) + 1)) begin
      hr = (ex >= int'(cur.hs)) && (ex <= int'(cur.he));
      vr = (ey >= int'(cur.vs)) && (ey <= int'(cur.ve));
      chk(int'(pixel_x), ex, "R2 pixel_x");
      chk(int'(pixel_y), ey, "R3 pixel_y");
      chk(int'(hsync), int'((hr && !cur.sc[5] && !cur.sc[1]) ^ cur.sc[3]), "R5/R8/R9 hsync");
      chk(int'(vsync), int'((vr && !cur.sc[6] && !cur.sc[1]) ^ cur.sc[4]), "R5/R8/R9 vsync");
      chk(int'(rgb_sync), int'(cur.sc[0] && !cur.sc[1] && (hr || vr)), "R10 rgb_sync");
      chk(int'(display_active),
          int'(cur.cr[1] && !cur.dc[1] && ex <= int'(cur.ha) && ey <= int'(cur.va)),
          "R6/R11 display_active");
      chk(int'(prefetch), int'(ex == int'(cur.pf)), "R7 prefetch");
      @(negedge clk);
      if (ex >= int'(cur.ht)) begin
        ex = 0;
        ey = (ey >= int'(cur.vt)) ? 0 : ey + 1;
      end else begin
        ex++;
      end
    end
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    ex = 0; ey = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(int'(pixel_x), 0, "R1 pixel_x");
    chk(int'(pixel_y), 0, "R1 pixel_y");
    chk(int'(hsync), 0, "R1 hsync");
    chk(int'(vsync), 0, "R1 vsync");
    chk(int'(display_active), 0, "R1 display_active");
    chk(int'(prefetch), 0, "R1 prefetch");
    chk(int'(rgb_sync), 0, "R1 rgb_sync");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(int'(hsync) + int'(vsync) + int'(prefetch), 0, "R1 after release");

    // table walk
    for (int e = 0; e < NCFG; e++) begin
      cur = TABLE[e];
      program_cfg(cur);
      run_frames(2);
    end

    // R4: stop mid-scan with both syncs inverted
    repeat (7) @(negedge clk);
    wr(10, 12'h18);
    wr(0, 0);
    repeat (4) @(negedge clk);
    chk(int'(pixel_x), 0, "R4 pixel_x held");
    chk(int'(pixel_y), 0, "R4 pixel_y held");
    chk(int'(hsync), 1, "R4 hsync idle level");
    chk(int'(vsync), 1, "R4 vsync idle level");
    chk(int'(display_active), 0, "R4 display_active");
    chk(int'(prefetch), 0, "R4 prefetch");
    chk(int'(rgb_sync), 0, "R4 rgb_sync");

    // R12: unmapped writes leave every setting intact
    for (int a = 12; a < 16; a++) wr(a, 12'hFFF);
    chk(int'(pixel_x), 0, "R12 still stopped");
    chk(int'(hsync), 1, "R12 sync control unchanged");
    wr(10, 0);
    cur.sc = 12'h000;
    cur.cr = 12'h003;
    wr(0, 3);
    run_frames(1);

    summary();
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule